// File: doc/BRIEF.md
# Lower-Memory Fence Guard

This block enforces a software-set protection boundary for a 16-bit processor with a 15-bit word address space. Software loads a boundary register, and every word address below that value counts as protected. A separate program action arms protection. While protection is armed, the guard watches each bus cycle. It raises a trap request on any of three kinds of fault: a store into the protected region, a jump whose target lies in that region, or an input/output instruction of any kind.

When a store is refused, the memory write strobe is withheld in the same cycle, so memory never changes. The address of the faulting instruction is captured in a capture register, and a later fault cannot overwrite it until software has read it. The interrupt logic acknowledges the trap, and that acknowledge disarms protection so the handler runs without limits. An independent loader-guard switch refuses stores to the highest 64 words, whether or not protection is armed.

Top module: `mem_fence_guard`

## Requirements
- R1: After reset the boundary is 0, protection is disarmed, trap_req and fault_pend are 0, and stores pass to mem_we.
- R2: A cycle with bound_ld high loads bound_din into bound_q at the next clock edge. A cycle with arm high arms protection (prot_on = 1) from the next edge.
- R3: The cycle kind is encoded on cyc_kind as 00 read, 01 store, 10 jump, 11 I/O. mem_we equals cyc_valid with a store kind, except that it is forced low in the same cycle when protection is armed and cyc_addr < bound_q.
- R4: With protection armed, a valid jump cycle whose cyc_addr < bound_q is a fault. A jump to an address at or above bound_q is not a fault.
- R5: With protection armed, any valid I/O cycle is a fault, whatever its address.
- R6: A fault sets trap_req at the next edge. trap_req then stays high until a cycle with trap_ack, and a new fault in that same cycle keeps it high.
- R7: On a fault while no capture is pending, instr_addr is stored in fault_addr and fault_pend goes to 1 at the next edge.
- R8: While fault_pend is 1, later faults leave fault_addr unchanged. A cycle with fault_rd or arm releases the capture: fault_pend clears, or a fault in that same cycle is captured anew.
- R9: trap_ack disarms protection at the next edge. If arm and trap_ack come in the same cycle, trap_ack wins.
- R10: When loader_sw is high, stores to addresses 32704 to 32767 are refused on mem_we, whatever the protection state, and no trap is raised for them. When loader_sw is low, such stores pass.
- R11: Read cycles and idle cycles never raise a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bound_ld | input | 1 | Load the boundary register |
| bound_din | input | 15 | New boundary value |
| arm | input | 1 | Program action that arms protection and releases the capture |
| trap_ack | input | 1 | Interrupt logic has taken the trap |
| fault_rd | input | 1 | Software read of the capture register; releases it |
| loader_sw | input | 1 | Loader-guard switch for the top 64 words |
| cyc_valid | input | 1 | A bus cycle is present |
| cyc_kind | input | 2 | 00 read, 01 store, 10 jump, 11 I/O |
| cyc_addr | input | 15 | Store address or jump target |
| instr_addr | input | 15 | Address of the instruction issuing the cycle |
| mem_we | output | 1 | Gated write strobe toward memory |
| bound_q | output | 15 | Current boundary |
| prot_on | output | 1 | Protection armed |
| trap_req | output | 1 | Trap request to the interrupt logic |
| fault_addr | output | 15 | Captured faulting instruction address |
| fault_pend | output | 1 | Capture holds an unread entry |

## Verification
A fault and a capture release can fall in the same cycle, for example a protected jump issued together with fault_rd or arm. Likewise, trap_ack can meet a fresh fault or an arm request. The random stimulus sets arm, fault_rd and trap_ack with independent probabilities while faults are frequent, and a directed sequence forces each collision. A cycle-level bench model judges each case: capture-over-release, set-over-acknowledge for the trap, and acknowledge-over-arm for protection.

// File: rtl/fence_pkg.sv
package fence_pkg;
   typedef enum logic [1:0] {
      CYC_RD  = 2'b00,
      CYC_WR  = 2'b01,
      CYC_JMP = 2'b10,
      CYC_IO  = 2'b11
   } cyc_kind_e;
endpackage

// File: rtl/fence_bound_cmp.sv
module fence_bound_cmp #(
   parameter int unsigned AW        = 15,
   parameter int unsigned LDR_WORDS = 64,
   parameter bit          LDR_EN    = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] bound,
   input  logic          loader_sw,
   output logic          below_bound,
   output logic          in_ldr_zone
);
   localparam int unsigned SPACE = 1 << AW;
   localparam logic [AW-1:0] TOP_BASE = AW'(SPACE - LDR_WORDS);

   assign below_bound = (addr < bound);

   generate
      if (LDR_EN) begin : g_ldr
         assign in_ldr_zone = loader_sw && (addr >= TOP_BASE);
      end else begin : g_no_ldr
         assign in_ldr_zone = loader_sw & 1'b0;
      end
   endgenerate
endmodule

// File: rtl/fence_ctl.sv
module fence_ctl #(
   parameter int unsigned AW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bound_ld,
   input  logic [AW-1:0] bound_din,
   input  logic          arm,
   input  logic          trap_ack,
   input  logic          fault,
   output logic [AW-1:0] bound_q,
   output logic          prot_on,
   output logic          trap_req
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bound_q  <= '0;
         prot_on  <= 1'b0;
         trap_req <= 1'b0;
      end else begin
         if (bound_ld) bound_q <= bound_din;
         if (trap_ack)      prot_on <= 1'b0;
         else if (arm)      prot_on <= 1'b1;
         trap_req <= fault | (trap_req & ~trap_ack);
      end
   end
endmodule

// File: rtl/fence_fault_latch.sv
module fence_fault_latch #(
   parameter int unsigned AW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fault,
   input  logic          release_i,
   input  logic [AW-1:0] instr_addr,
   output logic [AW-1:0] fault_addr,
   output logic          fault_pend
);
   logic take;
   assign take = fault & (~fault_pend | release_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_addr <= '0;
         fault_pend <= 1'b0;
      end else if (take) begin
         fault_addr <= instr_addr;
         fault_pend <= 1'b1;
      end else if (release_i) begin
         fault_pend <= 1'b0;
      end
   end
endmodule

// File: rtl/mem_fence_guard.sv
module mem_fence_guard #(
   parameter int unsigned AW        = 15,
   parameter int unsigned LDR_WORDS = 64,
   parameter bit          LDR_EN    = 1'b1,
   parameter bit          IO_TRAP   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bound_ld,
   input  logic [AW-1:0] bound_din,
   input  logic          arm,
   input  logic          trap_ack,
   input  logic          fault_rd,
   input  logic          loader_sw,
   input  logic          cyc_valid,
   input  logic [1:0]    cyc_kind,
   input  logic [AW-1:0] cyc_addr,
   input  logic [AW-1:0] instr_addr,
   output logic          mem_we,
   output logic [AW-1:0] bound_q,
   output logic          prot_on,
   output logic          trap_req,
   output logic [AW-1:0] fault_addr,
   output logic          fault_pend
);
   import fence_pkg::*;

   generate
      if (AW < 7 || AW > 24) begin : g_bad_aw
         $error("mem_fence_guard: AW out of range");
      end
      if (LDR_WORDS == 0 || LDR_WORDS >= (1 << AW)) begin : g_bad_ldr
         $error("mem_fence_guard: LDR_WORDS must be within the address space");
      end
   endgenerate

   cyc_kind_e kind;
   logic      below, ldr_hit, is_wr, is_jmp, is_io, fault, io_fault;

   assign kind   = cyc_kind_e'(cyc_kind);
   assign is_wr  = cyc_valid && (kind == CYC_WR);
   assign is_jmp = cyc_valid && (kind == CYC_JMP);
   assign is_io  = cyc_valid && (kind == CYC_IO);

   fence_bound_cmp #(.AW(AW), .LDR_WORDS(LDR_WORDS), .LDR_EN(LDR_EN)) u_cmp (
      .addr        (cyc_addr),
      .bound       (bound_q),
      .loader_sw   (loader_sw),
      .below_bound (below),
      .in_ldr_zone (ldr_hit)
   );

   generate
      if (IO_TRAP) begin : g_io
         assign io_fault = is_io;
      end else begin : g_no_io
         assign io_fault = 1'b0;
      end
   endgenerate

   assign fault  = prot_on & ((is_wr & below) | (is_jmp & below) | io_fault);
   assign mem_we = is_wr & ~(prot_on & below) & ~ldr_hit;

   fence_ctl #(.AW(AW)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bound_ld  (bound_ld),
      .bound_din (bound_din),
      .arm       (arm),
      .trap_ack  (trap_ack),
      .fault     (fault),
      .bound_q   (bound_q),
      .prot_on   (prot_on),
      .trap_req  (trap_req)
   );

   fence_fault_latch #(.AW(AW)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault      (fault),
      .release_i  (fault_rd | arm),
      .instr_addr (instr_addr),
      .fault_addr (fault_addr),
      .fault_pend (fault_pend)
   );
endmodule

// File: rtl/fence_guard_chk.sv
module fence_guard_chk #(
   parameter int unsigned AW        = 15,
   parameter int unsigned LDR_WORDS = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          arm,
   input logic          trap_ack,
   input logic          fault_rd,
   input logic          loader_sw,
   input logic          cyc_valid,
   input logic [1:0]    cyc_kind,
   input logic [AW-1:0] cyc_addr,
   input logic          mem_we,
   input logic [AW-1:0] bound_q,
   input logic          prot_on,
   input logic          trap_req,
   input logic [AW-1:0] fault_addr,
   input logic          fault_pend
);
   localparam logic [AW-1:0] TOP_BASE = AW'((1 << AW) - LDR_WORDS);

   p_store_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_on && cyc_valid && cyc_kind == 2'b01 && cyc_addr < bound_q) |-> !mem_we);

   p_jump_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_on && cyc_valid && cyc_kind == 2'b10 && cyc_addr < bound_q) |=> trap_req);

   p_io_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_on && cyc_valid && cyc_kind == 2'b11) |=> trap_req);

   p_trap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && !trap_ack) |=> trap_req);

   p_capture_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_pend && !fault_rd && !arm) |=> ($stable(fault_addr) && fault_pend));

   p_ack_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_ack |=> !prot_on);

   p_loader_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (loader_sw && cyc_valid && cyc_kind == 2'b01 && cyc_addr >= TOP_BASE) |-> !mem_we);

   p_read_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_req && (!cyc_valid || cyc_kind == 2'b00)) |=> !trap_req);
endmodule

bind mem_fence_guard fence_guard_chk #(.AW(AW), .LDR_WORDS(LDR_WORDS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arm        (arm),
   .trap_ack   (trap_ack),
   .fault_rd   (fault_rd),
   .loader_sw  (loader_sw),
   .cyc_valid  (cyc_valid),
   .cyc_kind   (cyc_kind),
   .cyc_addr   (cyc_addr),
   .mem_we     (mem_we),
   .bound_q    (bound_q),
   .prot_on    (prot_on),
   .trap_req   (trap_req),
   .fault_addr (fault_addr),
   .fault_pend (fault_pend)
);

// File: tb/mem_fence_guard_tb_top.sv
`timescale 1ns/1ps
module mem_fence_guard_tb_top;
   localparam int AW  = 15;
   localparam int TOP = 32704;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bound_ld = 0, arm = 0, trap_ack = 0, fault_rd = 0, loader_sw = 0, cyc_valid = 0;
   logic [1:0]    cyc_kind = 0;
   logic [AW-1:0] bound_din = 0, cyc_addr = 0, instr_addr = 0;
   logic          mem_we, prot_on, trap_req, fault_pend;
   logic [AW-1:0] bound_q, fault_addr;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // bench model state
   logic [AW-1:0] m_bound = 0, m_faddr = 0;
   logic          m_prot = 0, m_trap = 0, m_pend = 0;
   logic [1:0]    prev_kind = 0;
   logic          prev_valid = 0;

   always #4 clk = ~clk;

   mem_fence_guard dut_i (
      .clk(clk), .rst_n(rst_n), .bound_ld(bound_ld), .bound_din(bound_din), .arm(arm),
      .trap_ack(trap_ack), .fault_rd(fault_rd), .loader_sw(loader_sw), .cyc_valid(cyc_valid),
      .cyc_kind(cyc_kind), .cyc_addr(cyc_addr), .instr_addr(instr_addr), .mem_we(mem_we),
      .bound_q(bound_q), .prot_on(prot_on), .trap_req(trap_req), .fault_addr(fault_addr),
      .fault_pend(fault_pend));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_fault(input logic v, input logic [1:0] k, input logic [AW-1:0] a);
      logic below = (a < m_bound);
      return m_prot & v & (((k == 2'b01) & below) | ((k == 2'b10) & below) | (k == 2'b11));
   endfunction

   function automatic logic exp_we(input logic v, input logic [1:0] k, input logic [AW-1:0] a,
                                   input logic ldr);
      return v & (k == 2'b01) & ~(m_prot & (a < m_bound)) & ~(ldr & (a >= AW'(TOP)));
   endfunction

   // check registered outputs against the model (called at negedge)
   task automatic chk_state();
      string ttag;
      if (!prev_valid || prev_kind == 2'b00) ttag = "R11";
      else if (prev_kind == 2'b10) ttag = "R4";
      else if (prev_kind == 2'b11) ttag = "R5";
      else ttag = "R6";
      chk("R2", 32'(bound_q), 32'(m_bound));
      chk("R9", 32'(prot_on), 32'(m_prot));
      chk(ttag, 32'(trap_req), 32'(m_trap));
      chk("R7", 32'(fault_pend), 32'(m_pend));
      chk("R8", 32'(fault_addr), 32'(m_faddr));
   endtask

   task automatic step(input logic ld, input logic [AW-1:0] din, input logic ar, input logic ack,
                       input logic rd, input logic ldr, input logic v, input logic [1:0] k,
                       input logic [AW-1:0] a, input logic [AW-1:0] ia);
      logic f, rel;
      @(negedge clk);
      chk_state();
      bound_ld = ld; bound_din = din; arm = ar; trap_ack = ack; fault_rd = rd;
      loader_sw = ldr; cyc_valid = v; cyc_kind = k; cyc_addr = a; instr_addr = ia;
      #1;
      chk((ldr && a >= AW'(TOP)) ? "R10" : "R3", 32'(mem_we), 32'(exp_we(v, k, a, ldr)));
      f   = exp_fault(v, k, a);
      rel = rd | ar;
      if (f & (~m_pend | rel)) begin m_faddr = ia; m_pend = 1'b1; end
      else if (rel) m_pend = 1'b0;
      m_trap = f | (m_trap & ~ack);
      if (ack) m_prot = 1'b0; else if (ar) m_prot = 1'b1;
      if (ld) m_bound = din;
      prev_kind = k; prev_valid = v;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", 32'(bound_q), 0);
      chk("R1", 32'(prot_on), 0);
      chk("R1", 32'(trap_req), 0);
      chk("R1", 32'(fault_pend), 0);
      // R1: stores pass after reset
      step(0, 0, 0, 0, 0, 0, 1, 2'b01, 15'd5, 15'd1);
      // R2: load boundary 100 and arm
      step(1, 15'd100, 1, 0, 0, 0, 0, 2'b00, 0, 0);
      // R3: store just below / at boundary
      step(0, 0, 0, 0, 0, 0, 1, 2'b01, 15'd99, 15'd200);
      step(0, 0, 0, 0, 0, 0, 1, 2'b01, 15'd100, 15'd201);
      // R8: second fault (jump) while pending does not overwrite
      step(0, 0, 0, 0, 0, 0, 1, 2'b10, 15'd50, 15'd202);
      // R4: jump at boundary, no fault
      step(0, 0, 0, 0, 0, 0, 1, 2'b10, 15'd100, 15'd203);
      // R8: release by read together with I/O fault recaptures (R5)
      step(0, 0, 0, 0, 1, 0, 1, 2'b11, 15'd7000, 15'd204);
      // R9: ack and arm together, ack wins; R6 trap cleared
      step(0, 0, 1, 1, 0, 0, 0, 2'b00, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 2'b01, 15'd10, 15'd205);
      // R10: loader guard edges
      step(0, 0, 0, 0, 0, 1, 1, 2'b01, 15'd32704, 15'd206);
      step(0, 0, 0, 0, 0, 1, 1, 2'b01, 15'd32703, 15'd207);
      step(0, 0, 0, 0, 0, 0, 1, 2'b01, 15'd32767, 15'd208);
      // R6: re-arm, fault with ack in the same cycle keeps trap high
      step(0, 0, 1, 0, 0, 0, 0, 2'b00, 0, 0);
      step(0, 0, 0, 1, 0, 0, 1, 2'b11, 15'd3, 15'd209);
      step(0, 0, 0, 0, 0, 0, 1, 2'b00, 15'd1, 15'd210);
      // random phase
      for (int i = 0; i < 6000; i++) begin
         logic [AW-1:0] a, b;
         b = AW'($urandom_range(0, 32767));
         a = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(32690, 32767))
                                         : AW'($urandom_range(0, 32767));
         if ($urandom_range(0, 2) == 0) a = m_bound + AW'($urandom_range(0, 2)) - AW'(1);
         step($urandom_range(0, 15) == 0, b, $urandom_range(0, 7) == 0,
              $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
              1'($urandom_range(0, 1)), $urandom_range(0, 5) != 0,
              2'($urandom_range(0, 3)), a, AW'($urandom_range(0, 32767)));
      end
      @(negedge clk);
      chk_state();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule